// File: doc/BRIEF.md
# Windowed Sensor Frame Timing Generator

This block sequences readout of a pixel array. A column counter and a row counter walk through a frame made of blanking rows followed by the rows of a configurable window. From them the block derives a line-valid flag, a frame-valid flag and a one-clock frame-start strobe. The strobe leads the first active row by four row times, so the register layer can copy its pending settings into live ones before the image begins. It also produces the array column and row address of the pixel being read.

The window is set by a start column, a start row, a width and a height. Horizontal and vertical blanking can be programmed. Values below the minimum are raised to 43 columns and 4 rows.

A two-bit scan mode picks the order in which rows are read:
- Code 0 is plain sequential order.
- Code 1 is not a valid mode and behaves like code 0.
- Code 2 reads every even-numbered row of the window, then every odd-numbered row.
- Code 3 reads only the rows whose parity matches the start row.

The configuration inputs are the live copies and are expected to stay constant while a frame is in progress.

Top module: `sensor_frame_timing`

## Requirements
- R1: While `rst_n` is low, `line_valid`, `frame_valid` and `frame_start` are all 0.
- R2: A row lasts `cfg_win_width` + max(`cfg_hblank`, 43) clock cycles, so a horizontal blanking below 43 acts as 43.
- R3: A frame lasts (active rows + max(`cfg_vblank`, 4)) rows, so a vertical blanking below 4 acts as 4. The blanking rows come first in the frame.
- R4: `line_valid` is 1 during the first `cfg_win_width` clocks of each active row and 0 at all other times. While it is 1, `col_addr` equals `cfg_col_start` plus the clock index within the row. While it is 0, `col_addr` is 0.
- R5: `frame_valid` is 1 for every clock of every active row, including that row's horizontal blanking, and is 0 during the blanking rows.
- R6: `frame_start` is a one-clock pulse on the first clock of the row that lies exactly four rows before the first active row. It occurs once per frame, including the first clock after reset is released.
- R7: With scan mode 0 or 1, there are `cfg_win_height` active rows. The k-th active row (counting from 0) has `row_addr` = `cfg_row_start` + k. `row_addr` is 0 whenever `frame_valid` is 0.
- R8: With scan mode 2, the active rows are every even-numbered row in [`cfg_row_start`, `cfg_row_start`+`cfg_win_height`-1] in ascending order, followed by every odd-numbered row of that range in ascending order.
- R9: With scan mode 3, there are (`cfg_win_height`+1)/2 active rows (integer division). Their `row_addr` values are `cfg_row_start`, `cfg_row_start`+2, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_col_start | input | 10 | First array column of the window |
| cfg_row_start | input | 9 | First array row of the window |
| cfg_win_width | input | 10 | Window width in columns (1 to 752) |
| cfg_win_height | input | 9 | Window height in rows (1 to 480) |
| cfg_hblank | input | 10 | Horizontal blanking in clocks; minimum 43 |
| cfg_vblank | input | 12 | Vertical blanking in rows; minimum 4 |
| cfg_scan_mode | input | 2 | 0 and 1 sequential, 2 even rows then odd rows, 3 start-parity rows only |
| col_addr | output | 10 | Array column being read; 0 outside line-valid |
| row_addr | output | 9 | Array row being read; 0 outside frame-valid |
| line_valid | output | 1 | High on active columns of active rows |
| frame_valid | output | 1 | High across all active rows |
| frame_start | output | 1 | One-clock strobe, four rows ahead of frame-valid |

## Verification
The bench aims at the following corner cases:
- Blanking values below their minimums. A design that used them unclamped would produce short rows and a frame-start strobe too close to frame-valid, or one that wraps below zero.
- Interlaced ordering with both even and odd start rows, using an odd window height. A design that assumed the start row is even, or split the height the wrong way, would output a missing or repeated row address.
- Parity-only mode with an odd height. An off-by-one in the halving would drop the last row.
- A one-column, one-row window. This exposes comparisons that are off by one at the row edges.

For each of these, the bench measures the row period, the frame period and the lead of the strobe over frame-valid.

// File: rtl/sft_pkg.sv
// Package: shared types for the sensor frame timing generator.
// Assumes: scan mode arrives as a two-bit code with the values below.
package sft_pkg;

    typedef enum logic [1:0] {
        SCAN_SEQ       = 2'd0,
        SCAN_RESERVED  = 2'd1,
        SCAN_TWO_FIELD = 2'd2,
        SCAN_ONE_FIELD = 2'd3
    } scan_e;

endpackage

// File: rtl/sft_geometry.sv
// Module: sft_geometry
// Purpose: clamps the blanking settings to their minimums and derives the
// row length, the blanking row count, the active row count and the frame length.
// Assumes: the configuration is stable for the length of a frame.
module sft_geometry
    import sft_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int ROW_W      = 9,
    parameter int HB_W       = 10,
    parameter int VB_W       = 12,
    parameter int MIN_HBLANK = 43,
    parameter int MIN_VBLANK = 4,
    parameter int HCNT_W     = 11,
    parameter int VCNT_W     = 13
) (
    input  logic [COL_W-1:0]  win_width,
    input  logic [ROW_W-1:0]  win_height,
    input  logic [HB_W-1:0]   hblank,
    input  logic [VB_W-1:0]   vblank,
    input  scan_e             scan_mode,
    output logic [HCNT_W-1:0] row_len,
    output logic [VCNT_W-1:0] blank_rows,
    output logic [VCNT_W-1:0] active_rows,
    output logic [VCNT_W-1:0] frame_rows
);

    logic [HB_W-1:0] hb_eff;
    logic [VB_W-1:0] vb_eff;

    // Raise each blanking value to its minimum.
    always_comb begin
        hb_eff = (hblank < HB_W'(MIN_HBLANK)) ? HB_W'(MIN_HBLANK) : hblank;
        vb_eff = (vblank < VB_W'(MIN_VBLANK)) ? VB_W'(MIN_VBLANK) : vblank;
    end

    // Derive the row and frame lengths; the parity-only mode halves the height, rounding up.
    always_comb begin
        row_len    = HCNT_W'(win_width) + HCNT_W'(hb_eff);
        blank_rows = VCNT_W'(vb_eff);
        if (scan_mode == SCAN_ONE_FIELD)
            active_rows = (VCNT_W'(win_height) + VCNT_W'(1)) >> 1;
        else
            active_rows = VCNT_W'(win_height);
        frame_rows = blank_rows + active_rows;
    end

endmodule

// File: rtl/sft_counters.sv
// Module: sft_counters
// Purpose: free-running column and row counters that wrap at the row length
// and at the frame length.
// Assumes: row_len >= 2 and frame_rows >= 1. Wrapping uses >=, so a smaller
// length arriving mid-frame cannot run a counter past its end.
module sft_counters #(
    parameter int HCNT_W = 11,
    parameter int VCNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] row_len,
    input  logic [VCNT_W-1:0] frame_rows,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt
);

    logic h_last;
    logic v_last;

    // Detect the last clock of a row and the last row of a frame.
    always_comb begin
        h_last = (hcnt >= row_len - HCNT_W'(1));
        v_last = (vcnt >= frame_rows - VCNT_W'(1));
    end

    // Step the column every clock; step the row when a row ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + VCNT_W'(1);
        end else begin
            hcnt <= hcnt + HCNT_W'(1);
        end
    end

endmodule

// File: rtl/sft_row_map.sv
// Module: sft_row_map
// Purpose: turns the index of an active row into an array row address for
// the selected scan mode.
// Assumes: cfg_row_start + cfg_win_height fits in ROW_W bits.
module sft_row_map
    import sft_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int VCNT_W = 13
) (
    input  logic [ROW_W-1:0]  row_start,
    input  logic [ROW_W-1:0]  win_height,
    input  scan_e             scan_mode,
    input  logic [VCNT_W-1:0] line_idx,
    output logic [ROW_W-1:0]  row_addr
);

    localparam int RW = VCNT_W + 1;

    logic          odd_start;
    logic [RW-1:0] start_w;
    logic [RW-1:0] height_w;
    logic [RW-1:0] idx_w;
    logic [RW-1:0] first_cnt;
    logic [RW-1:0] first_base;
    logic [RW-1:0] second_base;
    logic [RW-1:0] addr_w;

    // Work out the size and base of the even field and the odd field.
    always_comb begin
        odd_start   = row_start[0];
        start_w     = RW'(row_start);
        height_w    = RW'(win_height);
        idx_w       = RW'(line_idx);
        first_cnt   = odd_start ? (height_w >> 1) : ((height_w + RW'(1)) >> 1);
        first_base  = start_w + RW'(odd_start);
        second_base = start_w + RW'(!odd_start);
    end

    // Choose the address formula for the scan mode.
    always_comb begin
        case (scan_mode)
            SCAN_TWO_FIELD: begin
                if (idx_w < first_cnt)
                    addr_w = first_base + (idx_w << 1);
                else
                    addr_w = second_base + ((idx_w - first_cnt) << 1);
            end
            SCAN_ONE_FIELD: addr_w = start_w + (idx_w << 1);
            default:        addr_w = start_w + idx_w;
        endcase
        row_addr = addr_w[ROW_W-1:0];
    end

endmodule

// File: rtl/sensor_frame_timing.sv
// Module: sensor_frame_timing (top)
// Purpose: produces the line-valid, frame-valid and frame-start timing and
// the column and row addresses for a windowed pixel array readout.
// Assumes: live configuration is held constant within a frame; FS_LEAD does
// not exceed MIN_VBLANK.
module sensor_frame_timing
    import sft_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int ROW_W      = 9,
    parameter int HB_W       = 10,
    parameter int VB_W       = 12,
    parameter int MIN_HBLANK = 43,
    parameter int MIN_VBLANK = 4,
    parameter int FS_LEAD    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] cfg_col_start,
    input  logic [ROW_W-1:0] cfg_row_start,
    input  logic [COL_W-1:0] cfg_win_width,
    input  logic [ROW_W-1:0] cfg_win_height,
    input  logic [HB_W-1:0]  cfg_hblank,
    input  logic [VB_W-1:0]  cfg_vblank,
    input  logic [1:0]       cfg_scan_mode,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic             line_valid,
    output logic             frame_valid,
    output logic             frame_start
);

    localparam int HCNT_W = ((COL_W > HB_W) ? COL_W : HB_W) + 1;
    localparam int VCNT_W = ((ROW_W > VB_W) ? ROW_W : VB_W) + 1;

    generate
        if (FS_LEAD > MIN_VBLANK) begin : g_bad_lead
            $error("FS_LEAD must not exceed MIN_VBLANK");
        end
    endgenerate

    scan_e             mode;
    logic [HCNT_W-1:0] row_len;
    logic [VCNT_W-1:0] blank_rows;
    logic [VCNT_W-1:0] active_rows;
    logic [VCNT_W-1:0] frame_rows;
    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic [VCNT_W-1:0] line_idx;
    logic [ROW_W-1:0]  mapped_row;
    logic              in_rows;

    assign mode = scan_e'(cfg_scan_mode);

    sft_geometry #(
        .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W), .VB_W(VB_W),
        .MIN_HBLANK(MIN_HBLANK), .MIN_VBLANK(MIN_VBLANK),
        .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
    ) u_geometry (
        .win_width  (cfg_win_width),
        .win_height (cfg_win_height),
        .hblank     (cfg_hblank),
        .vblank     (cfg_vblank),
        .scan_mode  (mode),
        .row_len    (row_len),
        .blank_rows (blank_rows),
        .active_rows(active_rows),
        .frame_rows (frame_rows)
    );

    sft_counters #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_len   (row_len),
        .frame_rows(frame_rows),
        .hcnt      (hcnt),
        .vcnt      (vcnt)
    );

    sft_row_map #(.ROW_W(ROW_W), .VCNT_W(VCNT_W)) u_row_map (
        .row_start (cfg_row_start),
        .win_height(cfg_win_height),
        .scan_mode (mode),
        .line_idx  (line_idx),
        .row_addr  (mapped_row)
    );

    // Decode the valid flags, the strobe and the addresses from the counter position.
    always_comb begin
        in_rows     = (vcnt >= blank_rows) && (vcnt < frame_rows);
        line_idx    = vcnt - blank_rows;
        frame_valid = in_rows;
        line_valid  = in_rows && (hcnt < HCNT_W'(cfg_win_width));
        frame_start = rst_n && (hcnt == '0) && (vcnt == blank_rows - VCNT_W'(FS_LEAD));
        col_addr    = line_valid ? (cfg_col_start + hcnt[COL_W-1:0]) : '0;
        row_addr    = frame_valid ? mapped_row : '0;
    end

    // Line-valid only ever appears inside frame-valid.
    p_lv_in_fv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);

    // The column address stays inside the window while line-valid is high.
    p_col_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> ((COL_W+1)'(col_addr) >= (COL_W+1)'(cfg_col_start)) &&
                       ((COL_W+1)'(col_addr) <  (COL_W+1)'(cfg_col_start) + (COL_W+1)'(cfg_win_width)));

    // The strobe lasts a single clock and never lands inside frame-valid.
    p_fs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    p_fs_outside_fv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !frame_valid);

    // Every reported row address lies inside the configured window.
    p_row_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ((ROW_W+1)'(row_addr) >= (ROW_W+1)'(cfg_row_start)) &&
                        ((ROW_W+1)'(row_addr) <  (ROW_W+1)'(cfg_row_start) + (ROW_W+1)'(cfg_win_height)));

    // Frame-valid only rises at the start of a row.
    p_fv_row_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> (hcnt == '0));

endmodule

// File: tb/sensor_frame_timing_bench.sv
module sensor_frame_timing_bench;

    localparam real CLK_NS = 20.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_col_start = '0;
    logic [8:0] cfg_row_start = '0;
    logic [9:0] cfg_win_width = '0;
    logic [8:0] cfg_win_height = '0;
    logic [9:0] cfg_hblank = '0;
    logic [11:0] cfg_vblank = '0;
    logic [1:0] cfg_scan_mode = '0;
    logic [9:0] col_addr;
    logic [8:0] row_addr;
    logic       line_valid;
    logic       frame_valid;
    logic       frame_start;

    int n_tests = 0;
    int n_fail  = 0;
    int row_list [0:1023];

    always #(CLK_NS / 2.0) clk = ~clk;

    sensor_frame_timing u_sensor_frame_timing (
        .clk(clk), .rst_n(rst_n),
        .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
        .cfg_win_width(cfg_win_width), .cfg_win_height(cfg_win_height),
        .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank),
        .cfg_scan_mode(cfg_scan_mode),
        .col_addr(col_addr), .row_addr(row_addr),
        .line_valid(line_valid), .frame_valid(frame_valid),
        .frame_start(frame_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Build the expected row order by walking the window, independent of any formula.
    function automatic int build_rows(input int rs, input int h, input int mode);
        int n = 0;
        if (mode == 2) begin
            for (int r = rs; r < rs + h; r++) if (r % 2 == 0) begin row_list[n] = r; n++; end
            for (int r = rs; r < rs + h; r++) if (r % 2 == 1) begin row_list[n] = r; n++; end
        end else if (mode == 3) begin
            for (int r = rs; r < rs + h; r++) if ((r % 2) == (rs % 2)) begin row_list[n] = r; n++; end
        end else begin
            for (int r = rs; r < rs + h; r++) begin row_list[n] = r; n++; end
        end
        return n;
    endfunction

    // One scenario: reset with a configuration, then compare every clock of several frames.
    task automatic run_case(input string name, input int cs, input int rs, input int w,
                            input int h, input int hb, input int vb, input int mode,
                            input int frames);
        int rl, vbe, n_act, frame_len, total;
        int e_lv, e_col, e_fv, e_fs, e_row;
        int fs_k0, fs_k1, lv_k0, lv_k1, fv_k0;
        bit prev_lv;
        string row_req;
        rl  = w + ((hb < 43) ? 43 : hb);
        vbe = (vb < 4) ? 4 : vb;
        n_act = build_rows(rs, h, mode);
        frame_len = rl * (n_act + vbe);
        total = frames * frame_len + 3;
        row_req = (mode == 2) ? "R8" : ((mode == 3) ? "R9" : "R7");
        $display("[TB] case %s", name);

        @(negedge clk);
        rst_n = 1'b0;
        cfg_col_start = 10'(cs); cfg_row_start = 9'(rs);
        cfg_win_width = 10'(w);  cfg_win_height = 9'(h);
        cfg_hblank = 10'(hb);    cfg_vblank = 12'(vb);
        cfg_scan_mode = 2'(mode);
        repeat (3) @(negedge clk);
        #1;
        // R1: all flags low while reset is held
        check(!line_valid && !frame_valid && !frame_start, "R1", "flags in reset",
              int'({line_valid, frame_valid, frame_start}), 0);

        @(negedge clk);
        rst_n = 1'b1;
        e_lv = 0; e_col = 0; e_fv = 0; e_fs = 0; e_row = 0;
        fs_k0 = -1; fs_k1 = -1; lv_k0 = -1; lv_k1 = -1; fv_k0 = -1;
        prev_lv = 1'b0;
        for (int k = 0; k < total; k++) begin
            int p, r, c, exp_col, exp_row;
            bit exp_fv, exp_lv, exp_fs;
            #1;
            p = k % frame_len;
            r = p / rl;
            c = p % rl;
            exp_fv  = (r >= vbe) && (r < vbe + n_act);
            exp_lv  = exp_fv && (c < w);
            exp_fs  = (c == 0) && (r == vbe - 4);
            exp_col = exp_lv ? cs + c : 0;
            exp_row = exp_fv ? row_list[r - vbe] : 0;
            if (line_valid != exp_lv) e_lv++;
            if (int'(col_addr) != exp_col) e_col++;
            if (frame_valid != exp_fv) e_fv++;
            if (frame_start != exp_fs) e_fs++;
            if (int'(row_addr) != exp_row) begin
                if (e_row == 0)
                    $display("[TB]   first row mismatch at k=%0d: got %0d want %0d", k, row_addr, exp_row);
                e_row++;
            end
            if (frame_start) begin
                if (fs_k0 < 0) fs_k0 = k; else if (fs_k1 < 0) fs_k1 = k;
            end
            if (line_valid && !prev_lv) begin
                if (lv_k0 < 0) lv_k0 = k; else if (lv_k1 < 0) lv_k1 = k;
            end
            if (frame_valid && fv_k0 < 0) fv_k0 = k;
            prev_lv = line_valid;
            @(negedge clk);
        end

        check(e_lv == 0,  "R4", "line_valid mismatches", e_lv, 0);
        check(e_col == 0, "R4", "col_addr mismatches", e_col, 0);
        check(e_fv == 0,  "R5", "frame_valid mismatches", e_fv, 0);
        check(e_fs == 0,  "R6", "frame_start mismatches", e_fs, 0);
        check(e_row == 0, row_req, "row_addr mismatches", e_row, 0);
        // R3: strobe-to-strobe distance is one whole frame
        check(fs_k1 - fs_k0 == frame_len, "R3", "frame period", fs_k1 - fs_k0, frame_len);
        // R6: strobe leads frame-valid by four rows
        check(fv_k0 - fs_k0 == 4 * rl, "R6", "strobe lead", fv_k0 - fs_k0, 4 * rl);
        // R2: consecutive line-valid rises are one row apart
        if (n_act >= 2)
            check(lv_k1 - lv_k0 == rl, "R2", "row period", lv_k1 - lv_k0, rl);
        else
            check(lv_k1 - lv_k0 == frame_len, "R2", "row period single row", lv_k1 - lv_k0, frame_len);
    endtask

    task automatic t_sequential;
        run_case("sequential R7", 5, 10, 8, 6, 43, 4, 0, 2);
    endtask

    task automatic t_clamp_and_reserved;
        // R2/R3 clamp: hblank 10 acts as 43, vblank 1 acts as 4; mode 1 acts as mode 0
        run_case("clamp R2 R3, mode 1 as R7", 100, 20, 12, 5, 10, 1, 1, 2);
    endtask

    task automatic t_two_field_even;
        run_case("two-field even start R8", 3, 12, 6, 5, 45, 6, 2, 2);
    endtask

    task automatic t_two_field_odd;
        run_case("two-field odd start R8", 7, 13, 6, 5, 44, 5, 2, 2);
    endtask

    task automatic t_one_field;
        run_case("one-field odd start R9", 1, 15, 9, 7, 43, 4, 3, 2);
    endtask

    task automatic t_tiny_window;
        run_case("one pixel window R4", 752, 4, 1, 1, 50, 9, 0, 3);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_sequential();
        t_clamp_and_reserved();
        t_two_field_even();
        t_two_field_odd();
        t_one_field();
        t_tiny_window();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule